// File: doc/BRIEF.md
# Compare-Capture Timer Channel

One 16-bit timer channel for a multi-channel timer unit. A prescaler divides the system clock by 1, 4, 16 or 64. A counter counts up on each prescaled tick. Register A serves as a compare value or as a capture target. Counting runs only while the channel's own bit in the shared start vector is set and the mode register selects normal counting.

On a compare match the channel sets status flag A. It can also clear the counter, and it drives an output pin with a per-channel action code. When the action code selects an input edge, the channel instead copies the counter into register A on a synchronized edge of the capture input. Flag A raises a level interrupt while its enable bit is set. Software clears the flag by writing 0 to it.

A periodic tick source is set up with clear-on-A and divide-by-64. The counter then runs 0..A and the interrupt repeats every A+1 prescaled ticks.

Top module: `cc_tmr_ch`

## Requirements
- R1: After reset the counter reads 0x0000 and register A reads 0xFFFF. The control, mode, I/O, enable and status registers read 0. `cmp_o` and `irq_o` are low.
- R2: Register map, byte offsets on `addr_i`:
  - 8-bit registers: control at 0, mode at 1, I/O at 2, interrupt enable at 4, status at 5. Data is on `wdata_i[7:0]` and reads return zero in `rdata_o[15:8]`.
  - 16-bit registers: counter at 6 and register A at 8. A write to either loads it directly.
  - Mode bits 7:4, enable bits 7:1 and status bits 7:1 read 0. Any other offset ignores writes and reads 0.
- R3: The counter holds its value unless `start_i[CH_IDX]` is 1 and the mode register is 0. Start bits of other channels have no effect.
- R4: Control bits 2:0 pick the prescaler: 0 gives one increment per clock, 1 one per 4 clocks, 2 one per 16, 3 one per 64, measured from the cycle the channel starts. Codes 4 to 7 give no increments.
- R5: With control bits 7:5 = 1, the tick that finds the counter equal to A loads 0, so the count cycles 0..A. With codes 0, 2, 5, 6 the counter wraps from 0xFFFF to 0.
- R6: With control bits 7:5 = 3, a high `sync_clr_i` while running clears the counter at the next clock edge. Under other clear codes `sync_clr_i` is ignored.
- R7: A tick on which the counter equals A sets status bit 0 (flag A) when the I/O code bit 3 is 0. This holds whatever the clear source.
- R8: Writing the status register with bit 0 = 0 clears flag A. Writing bit 0 = 1 leaves it unchanged. A set event in the same cycle wins.
- R9: `irq_o` is high exactly while flag A and enable bit 0 are both 1.
- R10: I/O register bits 3:0 set the pin action:
  - Writing 1, 2 or 3 forces `cmp_o` to 0; writing 5, 6 or 7 forces it to 1.
  - On each later match, codes 1/5 clear the pin, 2/6 set it, and 3/7 toggle it.
  - Codes 0 and 4 leave the pin unchanged.
- R11: I/O codes 8, 9 and 10 select capture on the rising, falling or both edges of `cap_i`. The input passes a 2-flop synchronizer. A qualified edge copies the counter into A and sets flag A, whether or not the channel runs. Codes 8 to 15 disable compare matches; codes 11 to 15 capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | NUM_CH | Shared start vector, one bit per channel |
| sync_clr_i | input | 1 | Synchronous clear request from the timer group |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| cap_i | input | 1 | Capture input pin |
| cmp_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Compare/capture A interrupt, level |

## Verification
The bench walks the counter onto and past register A. A design that clears one tick early or late shows a wrong count after exactly A and A+1 ticks, and an off-by-one compare sets the flag a tick early. It checks the 0xFFFF wrap, each prescale ratio over a span not divisible by the ratio, and start bits of other channels. The write-zero rule is probed with both polarities, which catches an inverted clear. Capture is driven with the wrong edge for each code, so a design that ignores the edge selector or samples the raw pin copies a wrong value into A.

// File: rtl/cc_tmr_pkg.sv
package cc_tmr_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_CTL  = 4'h0;
  localparam logic [REG_AW-1:0] OFS_MODE = 4'h1;
  localparam logic [REG_AW-1:0] OFS_IOC  = 4'h2;
  localparam logic [REG_AW-1:0] OFS_IEN  = 4'h4;
  localparam logic [REG_AW-1:0] OFS_STAT = 4'h5;
  localparam logic [REG_AW-1:0] OFS_CNT  = 4'h6;
  localparam logic [REG_AW-1:0] OFS_GRA  = 4'h8;

  typedef enum logic [2:0] {
    CLR_NONE = 3'd0,
    CLR_GRA  = 3'd1,
    CLR_GRB  = 3'd2,
    CLR_SYNC = 3'd3,
    CLR_RSV4 = 3'd4,
    CLR_GRC  = 3'd5,
    CLR_GRD  = 3'd6,
    CLR_RSV7 = 3'd7
  } clr_src_e;

  typedef struct packed {
    clr_src_e   clr;
    logic [1:0] edg;
    logic [2:0] psc;
  } ctl_t;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_CLEAR  = 2'd1,
    PIN_SET    = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_act_e;
endpackage

// File: rtl/cc_tmr_regs.sv
module cc_tmr_regs
  import cc_tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output ctl_t              ctl_o,
  output logic [3:0]        mode_o,
  output logic [7:0]        ioc_o,
  output logic              ien_o,
  output logic              ioc_wr_o,
  output logic              cnt_wr_o,
  output logic              gra_wr_o,
  output logic              stat_wr_o
);
  logic ctl_wr, mode_wr, ien_wr;

  always_comb begin
    ctl_wr    = 1'b0;
    mode_wr   = 1'b0;
    ioc_wr_o  = 1'b0;
    ien_wr    = 1'b0;
    stat_wr_o = 1'b0;
    cnt_wr_o  = 1'b0;
    gra_wr_o  = 1'b0;
    if (we_i) begin
      unique case (addr_i)
        OFS_CTL:  ctl_wr    = 1'b1;
        OFS_MODE: mode_wr   = 1'b1;
        OFS_IOC:  ioc_wr_o  = 1'b1;
        OFS_IEN:  ien_wr    = 1'b1;
        OFS_STAT: stat_wr_o = 1'b1;
        OFS_CNT:  cnt_wr_o  = 1'b1;
        OFS_GRA:  gra_wr_o  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      mode_o <= '0;
      ioc_o  <= '0;
      ien_o  <= 1'b0;
    end else begin
      if (ctl_wr)   ctl_o  <= ctl_t'(wdata_i);
      if (mode_wr)  mode_o <= wdata_i[3:0];
      if (ioc_wr_o) ioc_o  <= wdata_i;
      if (ien_wr)   ien_o  <= wdata_i[0];
    end
  end
endmodule

// File: rtl/cc_tmr_prescale.sv
module cc_tmr_prescale #(
  parameter int unsigned PSC_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] pre_q;
  logic [PSC_W-1:0] mask;

  // divide by 4**sel for sel 0..3
  always_comb mask = PSC_W'((32'd1 << {sel_i[1:0], 1'b0}) - 32'd1);

  assign tick_o = run_i && !sel_i[2] && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cc_tmr_capsync.sv
module cc_tmr_capsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic [3:0] code_i,
  output logic       evt_o
);
  logic [STAGES:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b0;
    else         sh_q[0] <= cap_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[g] <= 1'b0;
      else         sh_q[g] <= sh_q[g-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

  always_comb begin
    unique case (code_i)
      4'd8:    evt_o = rise;
      4'd9:    evt_o = fall;
      4'd10:   evt_o = rise | fall;
      default: evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_tmr_count.sv
module cc_tmr_count
  import cc_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  clr_src_e         clr_i,
  input  logic             sync_clr_i,
  input  logic             cap_mode_i,
  input  logic             cap_evt_i,
  input  logic             cnt_wr_i,
  input  logic             gra_wr_i,
  input  logic             stat_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] gra_o,
  output logic             flag_o,
  output logic             cmp_evt_o
);
  assign cmp_evt_o = tick_i && !cap_mode_i && (cnt_o == gra_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (cnt_wr_i) begin
      cnt_o <= wdata_i;
    end else if (run_i && (clr_i == CLR_SYNC) && sync_clr_i) begin
      cnt_o <= '0;
    end else if (tick_i) begin
      if (cmp_evt_o && (clr_i == CLR_GRA)) cnt_o <= '0;
      else                                 cnt_o <= cnt_o + 1'b1;
    end
  end

  // capture has priority over a bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gra_o <= '1;
    else if (cap_evt_i) gra_o <= cnt_o;
    else if (gra_wr_i)  gra_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         flag_o <= 1'b0;
    else if (cmp_evt_o || cap_evt_i)     flag_o <= 1'b1;
    else if (stat_wr_i && !wdata_i[0])   flag_o <= 1'b0;
  end
endmodule

// File: rtl/cc_tmr_outpin.sv
module cc_tmr_outpin
  import cc_tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ioc_wr_i,
  input  logic [3:0] new_code_i,
  input  logic [3:0] code_i,
  input  logic       cmp_evt_i,
  output logic       pin_o
);
  pin_act_e act;
  assign act = pin_act_e'(code_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o <= 1'b0;
    end else if (ioc_wr_i) begin
      if (!new_code_i[3] && (new_code_i[1:0] != 2'd0)) pin_o <= new_code_i[2];
    end else if (cmp_evt_i && !code_i[3]) begin
      unique case (act)
        PIN_CLEAR:  pin_o <= 1'b0;
        PIN_SET:    pin_o <= 1'b1;
        PIN_TOGGLE: pin_o <= ~pin_o;
        default:    pin_o <= pin_o;
      endcase
    end
  end
endmodule

// File: rtl/cc_tmr_ch.sv
module cc_tmr_ch
  import cc_tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned NUM_CH      = 5,
  parameter int unsigned CH_IDX      = 0,
  parameter int unsigned PSC_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] start_i,
  input  logic              sync_clr_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              cap_i,
  output logic              cmp_o,
  output logic              irq_o
);
  localparam int unsigned PAD_B = CNT_W - 8;
  localparam int unsigned PAD_M = CNT_W - 4;
  localparam int unsigned PAD_1 = CNT_W - 1;

  ctl_t             ctl;
  logic [3:0]       mode;
  logic [7:0]       ioc;
  logic             ien;
  logic             ioc_wr, cnt_wr, gra_wr, stat_wr;
  logic             run_eff, tick, cap_mode, cap_evt, cmp_evt, flag;
  logic [CNT_W-1:0] cnt, gra;

  assign run_eff  = start_i[CH_IDX] && (mode == 4'd0);
  assign cap_mode = ioc[3];

  cc_tmr_regs i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i,
    .wdata_i   (wdata_i[7:0]),
    .ctl_o     (ctl),
    .mode_o    (mode),
    .ioc_o     (ioc),
    .ien_o     (ien),
    .ioc_wr_o  (ioc_wr),
    .cnt_wr_o  (cnt_wr),
    .gra_wr_o  (gra_wr),
    .stat_wr_o (stat_wr)
  );

  cc_tmr_prescale #(.PSC_W(PSC_W)) i_psc (
    .clk_i, .rst_ni,
    .run_i  (run_eff),
    .sel_i  (ctl.psc),
    .tick_o (tick)
  );

  cc_tmr_capsync #(.STAGES(SYNC_STAGES)) i_cap (
    .clk_i, .rst_ni, .cap_i,
    .code_i (ioc[3:0]),
    .evt_o  (cap_evt)
  );

  cc_tmr_count #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .run_i      (run_eff),
    .tick_i     (tick),
    .clr_i      (ctl.clr),
    .sync_clr_i,
    .cap_mode_i (cap_mode),
    .cap_evt_i  (cap_evt),
    .cnt_wr_i   (cnt_wr),
    .gra_wr_i   (gra_wr),
    .stat_wr_i  (stat_wr),
    .wdata_i,
    .cnt_o      (cnt),
    .gra_o      (gra),
    .flag_o     (flag),
    .cmp_evt_o  (cmp_evt)
  );

  cc_tmr_outpin i_pin (
    .clk_i, .rst_ni,
    .ioc_wr_i   (ioc_wr),
    .new_code_i (wdata_i[3:0]),
    .code_i     (ioc[3:0]),
    .cmp_evt_i  (cmp_evt),
    .pin_o      (cmp_o)
  );

  assign irq_o = flag & ien;

  always_comb begin
    unique case (addr_i)
      OFS_CTL:  rdata_o = {{PAD_B{1'b0}}, ctl};
      OFS_MODE: rdata_o = {{PAD_M{1'b0}}, mode};
      OFS_IOC:  rdata_o = {{PAD_B{1'b0}}, ioc};
      OFS_IEN:  rdata_o = {{PAD_1{1'b0}}, ien};
      OFS_STAT: rdata_o = {{PAD_1{1'b0}}, flag};
      OFS_CNT:  rdata_o = cnt;
      OFS_GRA:  rdata_o = gra;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cc_tmr_ch_chk.sv
module cc_tmr_ch_chk
  import cc_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic              run,
  input logic              tick,
  input logic [2:0]        clr,
  input logic              cap_mode,
  input logic              cap_evt,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  gra,
  input logic              flag
);
  logic cnt_wr;
  assign cnt_wr = we_i && (addr_i == OFS_CNT);

  AST_CLEAR_ON_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !cap_mode && (cnt == gra) && (clr == 3'd1) && !cnt_wr |=> cnt == '0); // R5

  AST_FLAG_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !cap_mode && (cnt == gra) |=> flag); // R7

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !cnt_wr |=> $stable(cnt)); // R3

  AST_FLAG_W0C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> $past(we_i && (addr_i == OFS_STAT) && !wdata_i[0])); // R8

  AST_CAPTURE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt |=> (gra == $past(cnt)) && flag); // R11
endmodule

bind cc_tmr_ch cc_tmr_ch_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .run      (run_eff),
  .tick     (tick),
  .clr      (ctl.clr),
  .cap_mode (cap_mode),
  .cap_evt  (cap_evt),
  .cnt      (cnt),
  .gra      (gra),
  .flag     (flag)
);

// File: tb/test_cc_tmr_ch.sv
`timescale 1ns/1ps
module test_cc_tmr_ch;
  localparam int unsigned NCH = 5;
  localparam int unsigned IDX = 2;
  localparam logic [NCH-1:0] ON = NCH'(1) << IDX;
  localparam int unsigned NV = 12;
  // {addr, wdata, expected readback}
  localparam logic [35:0] VEC [NV] = '{
    {4'h0, 16'hAB5A, 16'h005A},
    {4'h1, 16'h00FF, 16'h000F},
    {4'h2, 16'h00C4, 16'h00C4},
    {4'h4, 16'h00FF, 16'h0001},
    {4'h5, 16'h00FF, 16'h0000},
    {4'h6, 16'h1234, 16'h1234},
    {4'h8, 16'hBEEF, 16'hBEEF},
    {4'h3, 16'h00FF, 16'h0000},
    {4'h7, 16'hFFFF, 16'h0000},
    {4'h1, 16'h0000, 16'h0000},
    {4'h0, 16'h0000, 16'h0000},
    {4'h2, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] start = '0;
  logic sync_clr = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic cap = 1'b0;
  logic cmp, irq;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cc_tmr_ch #(.NUM_CH(NCH), .CH_IDX(IDX)) i_cc_tmr_ch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sync_clr_i(sync_clr),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cap_i(cap), .cmp_o(cmp), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic run(input int k);
    @(negedge clk);
    start = ON;
    repeat (k) @(negedge clk);
    start = '0;
  endtask

  task automatic cap_to(input logic v);
    @(negedge clk);
    cap = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1 ctl", 4'h0, 16'h0000);
    rdchk("R1 mode", 4'h1, 16'h0000);
    rdchk("R1 ioc", 4'h2, 16'h0000);
    rdchk("R1 ien", 4'h4, 16'h0000);
    rdchk("R1 stat", 4'h5, 16'h0000);
    rdchk("R1 cnt", 4'h6, 16'h0000);
    rdchk("R1 rega", 4'h8, 16'hFFFF);
    chk("R1 cmp_o", {15'd0, cmp}, 16'd0);
    chk("R1 irq_o", {15'd0, irq}, 16'd0);

    // R2 register map walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rdchk("R2 map", VEC[i][35:32], VEC[i][15:0]);
    end

    // R5 R7 R9 clear on A, divide by 1
    wr(4'h0, 16'h0020); wr(4'h8, 16'h0003); wr(4'h6, 16'h0000); wr(4'h4, 16'h0001);
    run(3);
    rdchk("R5 cnt at A", 4'h6, 16'h0003);
    rdchk("R7 no early flag", 4'h5, 16'h0000);
    run(1);
    rdchk("R5 wrap to 0", 4'h6, 16'h0000);
    rdchk("R7 flag on match", 4'h5, 16'h0001);
    chk("R9 irq set", {15'd0, irq}, 16'd1);
    run(4);
    rdchk("R5 period A+1", 4'h6, 16'h0000);

    // R8 write-zero-to-clear
    wr(4'h5, 16'h0001);
    rdchk("R8 write one keeps", 4'h5, 16'h0001);
    wr(4'h5, 16'h00FE);
    rdchk("R8 write zero clears", 4'h5, 16'h0000);
    chk("R9 irq drops", {15'd0, irq}, 16'd0);
    run(4);
    wr(4'h4, 16'h0000);
    rdchk("R9 flag still set", 4'h5, 16'h0001);
    chk("R9 irq masked", {15'd0, irq}, 16'd0);
    wr(4'h5, 16'h0000);

    // R4 prescaler
    wr(4'h0, 16'h0001); wr(4'h6, 16'h0000); run(10);
    rdchk("R4 div4", 4'h6, 16'h0002);
    wr(4'h0, 16'h0002); wr(4'h6, 16'h0000); run(35);
    rdchk("R4 div16", 4'h6, 16'h0002);
    wr(4'h0, 16'h0003); wr(4'h6, 16'h0000); run(130);
    rdchk("R4 div64", 4'h6, 16'h0002);
    wr(4'h0, 16'h0004); wr(4'h6, 16'h0000); run(20);
    rdchk("R4 code4 stops", 4'h6, 16'h0000);

    // R5 free-running wrap
    wr(4'h0, 16'h0000); wr(4'h8, 16'h0005); wr(4'h6, 16'hFFFE); run(3);
    rdchk("R5 ffff wrap", 4'h6, 16'h0001);
    rdchk("R7 no match", 4'h5, 16'h0000);

    // R7 flag with clear source 2, no clear
    wr(4'h0, 16'h0040); wr(4'h8, 16'h0002); wr(4'h6, 16'h0000); run(5);
    rdchk("R5 code2 no clear", 4'h6, 16'h0005);
    rdchk("R7 flag code2", 4'h5, 16'h0001);
    wr(4'h5, 16'h0000);

    // R6 synchronous clear
    wr(4'h0, 16'h0060); wr(4'h6, 16'h0100);
    sync_clr = 1'b1; run(1); sync_clr = 1'b0;
    rdchk("R6 sync clear", 4'h6, 16'h0000);
    wr(4'h0, 16'h0000); wr(4'h6, 16'h0100);
    sync_clr = 1'b1; run(1); sync_clr = 1'b0;
    rdchk("R6 ignored", 4'h6, 16'h0101);

    // R3 run gating
    wr(4'h6, 16'h0050);
    @(negedge clk); start = ~ON;
    repeat (10) @(negedge clk); start = '0;
    rdchk("R3 other bits", 4'h6, 16'h0050);
    wr(4'h1, 16'h0002); run(10);
    rdchk("R3 mode nonzero", 4'h6, 16'h0050);
    wr(4'h1, 16'h0000);

    // R10 output pin
    wr(4'h0, 16'h0020); wr(4'h8, 16'h0001); wr(4'h6, 16'h0000);
    wr(4'h2, 16'h0003);
    chk("R10 init 0", {15'd0, cmp}, 16'd0);
    run(2);
    chk("R10 toggle up", {15'd0, cmp}, 16'd1);
    run(2);
    chk("R10 toggle down", {15'd0, cmp}, 16'd0);
    wr(4'h2, 16'h0005);
    chk("R10 init 1", {15'd0, cmp}, 16'd1);
    run(2);
    chk("R10 clear", {15'd0, cmp}, 16'd0);
    run(2);
    chk("R10 clear stays", {15'd0, cmp}, 16'd0);
    wr(4'h2, 16'h0002);
    run(2);
    chk("R10 set", {15'd0, cmp}, 16'd1);
    wr(4'h2, 16'h0000);
    run(2);
    chk("R10 hold", {15'd0, cmp}, 16'd1);
    wr(4'h2, 16'h0007);
    run(2);
    chk("R10 init1 toggle", {15'd0, cmp}, 16'd0);
    wr(4'h5, 16'h0000);

    // R11 capture
    wr(4'h0, 16'h0000); wr(4'h2, 16'h0008); wr(4'h6, 16'h0ABC);
    cap_to(1'b1);
    rdchk("R11 rise capture", 4'h8, 16'h0ABC);
    rdchk("R11 capture flag", 4'h5, 16'h0001);
    wr(4'h5, 16'h0000); wr(4'h6, 16'h0111);
    cap_to(1'b0);
    rdchk("R11 fall ignored", 4'h8, 16'h0ABC);
    rdchk("R11 no flag", 4'h5, 16'h0000);
    wr(4'h2, 16'h0009); wr(4'h6, 16'h0222);
    cap_to(1'b1);
    rdchk("R11 rise ignored", 4'h8, 16'h0ABC);
    cap_to(1'b0);
    rdchk("R11 fall capture", 4'h8, 16'h0222);
    wr(4'h5, 16'h0000);
    wr(4'h2, 16'h000A); wr(4'h6, 16'h0333);
    cap_to(1'b1);
    rdchk("R11 both rise", 4'h8, 16'h0333);
    wr(4'h6, 16'h0444);
    cap_to(1'b0);
    rdchk("R11 both fall", 4'h8, 16'h0444);
    wr(4'h2, 16'h000B); wr(4'h6, 16'h0555);
    cap_to(1'b1);
    rdchk("R11 code11 none", 4'h8, 16'h0444);
    cap_to(1'b0);
    wr(4'h5, 16'h0000);
    wr(4'h2, 16'h0008); wr(4'h0, 16'h0020); wr(4'h8, 16'h0002); wr(4'h6, 16'h0000);
    run(5);
    rdchk("R11 compare off", 4'h6, 16'h0005);
    rdchk("R11 no match flag", 4'h5, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule